// File: doc/BRIEF.md
# Shared-Bus Register Transfer Unit

This unit holds four general-purpose registers of a parameterized width that exchange data over a single shared bus. A two-bit source select picks which register drives the bus. The bus is built as one selection network per bit position, and each network gathers the bits of equal weight from all four registers. A decoder with an enable input turns the select into one-hot driver grants. When the enable is low, no register is granted and the bus reads as zero.

Every register has its own load control, which copies the bus value into that register on the next rising clock edge. A swap path exchanges the contents of any two registers in one edge. An external parallel-load input can place a value into each register directly. A synchronous active-high reset clears all four registers.

Controls are sampled at a clock edge. A control raised just after edge t therefore acts at edge t+1. A control held high acts again at every edge.

Top module: `rbx_regbus`

## Requirements
- R1: While `rst` is 1 at a rising edge, all four registers become zero. This overrides every load and swap control.
- R2: With `bus_en` at 1, `bus_out` equals the register chosen by `src_sel`: 2'b00 picks register 0, 2'b01 register 1, 2'b10 register 2 and 2'b11 register 3. Register k occupies `reg_out[k*DATA_W +: DATA_W]`.
- R3: With `bus_en` at 0, `bus_out` is all zeros, and a bus load in that cycle writes zero.
- R4: A register whose `ld_en[k]` bit is 1 takes the bus value at the rising edge. This applies when no swap and no parallel load claims that register. A load held high repeats at every edge. A register with no active control keeps its value.
- R5: Registers change only at a rising edge. Controls applied between edges leave `reg_out` unchanged until the next edge.
- R6: A transfer leaves the source register's value intact. A register that is both source and destination reloads its own value unchanged.
- R7: With `xchg_en` at 1 and `xchg_a` different from `xchg_b`, the two registers named by those fields swap contents in one edge. When the two fields are equal, the swap has no effect.
- R8: A register taking part in a swap ignores its `par_ld` and `ld_en` bits in that cycle. The other registers still load as usual.
- R9: A register with `par_ld[k]` at 1 takes `par_data[k*DATA_W +: DATA_W]`. This wins over its bus load.
- R10: At most one register is granted the bus at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| src_sel | input | 2 | Bus source register index |
| bus_en | input | 1 | Enables the driver decoder |
| ld_en | input | 4 | Per-register load from bus |
| par_ld | input | 4 | Per-register external parallel load |
| par_data | input | 4*DATA_W | External load values, register k in slice k |
| xchg_en | input | 1 | Swap enable |
| xchg_a | input | 2 | First swap register index |
| xchg_b | input | 2 | Second swap register index |
| bus_out | output | DATA_W | Current bus value |
| reg_out | output | 4*DATA_W | Register contents, register k in slice k |

## Verification
The properties assume that controls are stable around each rising edge. They also assume that, after reset, every input is driven to a known value, so that the decoder grant and the per-register priority are never evaluated on unknowns. The bench drives every control on the falling edge and holds it for a full cycle, and it holds reset through the first edge so that each register starts at zero. The bench sweeps all 16 source and destination pairs and all 16 swap index pairs. Before each of these sweep steps it reloads distinct register values, so that a wrong route or a missed swap always shows up as a value mismatch.

// File: rtl/rbx_pkg.sv
package rbx_pkg;
    localparam int NREG  = 4;
    localparam int SEL_W = $clog2(NREG);

    typedef logic [SEL_W-1:0] reg_idx_t;
endpackage

// File: rtl/rbx_src_decoder.sv
module rbx_src_decoder
    import rbx_pkg::*;
(
    input  reg_idx_t        sel,
    input  logic            en,
    output logic [NREG-1:0] grant
);
    // One grant line per register; all low when the decoder is disabled.
    for (genvar i = 0; i < NREG; i++) begin : g_dec
        assign grant[i] = en && (sel == SEL_W'(i));
    end
endmodule

// File: rtl/rbx_bus_mux.sv
module rbx_bus_mux
    import rbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [NREG-1:0][DATA_W-1:0] regs,
    input  logic [NREG-1:0]             grant,
    output logic [DATA_W-1:0]           bus
);
    // Each bus line ANDs the same-weight bit of every register with its grant
    // and ORs the results, standing in for gated drivers on a shared wire.
    for (genvar b = 0; b < DATA_W; b++) begin : g_line
        logic [NREG-1:0] column;
        for (genvar i = 0; i < NREG; i++) begin : g_tap
            assign column[i] = regs[i][b] & grant[i];
        end
        assign bus[b] = |column;
    end
endmodule

// File: rtl/rbx_next_regs.sv
module rbx_next_regs
    import rbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [NREG-1:0][DATA_W-1:0] regs_q,
    input  logic [DATA_W-1:0]           bus,
    input  logic [NREG-1:0]             ld_en,
    input  logic [NREG-1:0]             par_ld,
    input  logic [NREG-1:0][DATA_W-1:0] par_data,
    input  logic                        xchg_en,
    input  reg_idx_t                    xchg_a,
    input  reg_idx_t                    xchg_b,
    output logic [NREG-1:0][DATA_W-1:0] regs_d
);
    logic swap_live;
    assign swap_live = xchg_en && (xchg_a != xchg_b);

    // Per register: swap, then external load, then bus load, else hold.
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic in_a, in_b;
        assign in_a = swap_live && (xchg_a == SEL_W'(i));
        assign in_b = swap_live && (xchg_b == SEL_W'(i));

        always_comb begin
            if (in_a) begin
                regs_d[i] = regs_q[xchg_b];
            end else if (in_b) begin
                regs_d[i] = regs_q[xchg_a];
            end else if (par_ld[i]) begin
                regs_d[i] = par_data[i];
            end else if (ld_en[i]) begin
                regs_d[i] = bus;
            end else begin
                regs_d[i] = regs_q[i];
            end
        end
    end
endmodule

// File: rtl/rbx_regbus.sv
module rbx_regbus
    import rbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SEL_W-1:0]       src_sel,
    input  logic                   bus_en,
    input  logic [NREG-1:0]        ld_en,
    input  logic [NREG-1:0]        par_ld,
    input  logic [NREG*DATA_W-1:0] par_data,
    input  logic                   xchg_en,
    input  logic [SEL_W-1:0]       xchg_a,
    input  logic [SEL_W-1:0]       xchg_b,
    output logic [DATA_W-1:0]      bus_out,
    output logic [NREG*DATA_W-1:0] reg_out
);
    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
    } state_t;

    state_t                      s_q, s_d;
    logic [NREG-1:0]             drv;
    logic [DATA_W-1:0]           bus;
    logic [NREG-1:0][DATA_W-1:0] par_vec;
    logic [NREG-1:0][DATA_W-1:0] nxt;

    assign par_vec = par_data;

    rbx_src_decoder u_dec (
        .sel   (src_sel),
        .en    (bus_en),
        .grant (drv)
    );

    rbx_bus_mux #(.DATA_W(DATA_W)) u_mux (
        .regs  (s_q.regs),
        .grant (drv),
        .bus   (bus)
    );

    rbx_next_regs #(.DATA_W(DATA_W)) u_next (
        .regs_q   (s_q.regs),
        .bus      (bus),
        .ld_en    (ld_en),
        .par_ld   (par_ld),
        .par_data (par_vec),
        .xchg_en  (xchg_en),
        .xchg_a   (xchg_a),
        .xchg_b   (xchg_b),
        .regs_d   (nxt)
    );

    always_comb begin
        s_d.regs = nxt;
        if (rst) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign bus_out = bus;
    assign reg_out = s_q.regs;
endmodule

// File: rtl/rbx_regbus_chk.sv
module rbx_regbus_chk
    import rbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic [SEL_W-1:0]       src_sel,
    input logic                   bus_en,
    input logic [NREG-1:0]        ld_en,
    input logic [NREG-1:0]        par_ld,
    input logic                   xchg_en,
    input logic [SEL_W-1:0]       xchg_a,
    input logic [SEL_W-1:0]       xchg_b,
    input logic [DATA_W-1:0]      bus_out,
    input logic [NREG*DATA_W-1:0] reg_out,
    input logic [NREG-1:0]        drv
);
    // R10: decoder never grants two sources.
    a_r10_single_driver: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drv));

    // R3: idle bus reads zero.
    a_r3_idle_bus_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_en |-> bus_out == '0);

    // R2: bus follows the selected register.
    a_r2_bus_source: assert property (@(posedge clk) disable iff (rst)
        bus_en |-> bus_out == reg_out[src_sel*DATA_W +: DATA_W]);

    // R1: reset clears everything on the next edge.
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> reg_out == '0);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic in_swap;
        assign in_swap = xchg_en && (xchg_a != xchg_b)
                         && (xchg_a == SEL_W'(i) || xchg_b == SEL_W'(i));

        // R4: bus load lands one edge later.
        a_r4_bus_load: assert property (@(posedge clk) disable iff (rst)
            (ld_en[i] && !par_ld[i] && !in_swap)
            |=> reg_out[i*DATA_W +: DATA_W] == $past(bus_out));

        // R4 / R6: idle register holds.
        a_r4_hold: assert property (@(posedge clk) disable iff (rst)
            (!ld_en[i] && !par_ld[i] && !in_swap)
            |=> $stable(reg_out[i*DATA_W +: DATA_W]));

        for (genvar j = i + 1; j < NREG; j++) begin : g_pair
            // R7: pair swap in one edge.
            a_r7_swap: assert property (@(posedge clk) disable iff (rst)
                (xchg_en && ((xchg_a == SEL_W'(i) && xchg_b == SEL_W'(j)) ||
                             (xchg_a == SEL_W'(j) && xchg_b == SEL_W'(i))))
                |=> (reg_out[i*DATA_W +: DATA_W] == $past(reg_out[j*DATA_W +: DATA_W]))
                 && (reg_out[j*DATA_W +: DATA_W] == $past(reg_out[i*DATA_W +: DATA_W])));
        end
    end
endmodule

bind rbx_regbus rbx_regbus_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .src_sel (src_sel),
    .bus_en  (bus_en),
    .ld_en   (ld_en),
    .par_ld  (par_ld),
    .xchg_en (xchg_en),
    .xchg_a  (xchg_a),
    .xchg_b  (xchg_b),
    .bus_out (bus_out),
    .reg_out (reg_out),
    .drv     (drv)
);

// File: tb/rbx_regbus_bench.sv
module rbx_regbus_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   src_sel;
    logic         bus_en;
    logic [3:0]   ld_en;
    logic [3:0]   par_ld;
    logic [4*W-1:0] par_data;
    logic         xchg_en;
    logic [1:0]   xchg_a, xchg_b;
    logic [W-1:0] bus_out;
    logic [4*W-1:0] reg_out;

    int chk_cnt  = 0;
    int fail_cnt = 0;
    bit done     = 0;
    logic [W-1:0] exp_r [4];

    always #10 clk = ~clk;

    rbx_regbus #(.DATA_W(W)) u_rbx_regbus (
        .clk(clk), .rst(rst), .src_sel(src_sel), .bus_en(bus_en),
        .ld_en(ld_en), .par_ld(par_ld), .par_data(par_data),
        .xchg_en(xchg_en), .xchg_a(xchg_a), .xchg_b(xchg_b),
        .bus_out(bus_out), .reg_out(reg_out)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        chk_cnt++;
        if (act !== exp) begin
            fail_cnt++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        rst = 0; bus_en = 0; src_sel = 0; ld_en = 0; par_ld = 0;
        par_data = '0; xchg_en = 0; xchg_a = 0; xchg_b = 0;
    endtask

    // Apply the currently driven controls for one edge and compare with the
    // expected next state derived from the requirement priorities.
    task automatic apply(input string tag);
        logic [W-1:0] bus_e;
        logic [W-1:0] nxt [4];
        bit swap;
        bus_e = bus_en ? exp_r[src_sel] : '0;
        swap  = xchg_en && (xchg_a != xchg_b);
        for (int i = 0; i < 4; i++) begin
            if (rst) nxt[i] = '0;
            else if (swap && xchg_a == i[1:0]) nxt[i] = exp_r[xchg_b];
            else if (swap && xchg_b == i[1:0]) nxt[i] = exp_r[xchg_a];
            else if (par_ld[i]) nxt[i] = par_data[i*W +: W];
            else if (ld_en[i]) nxt[i] = bus_e;
            else nxt[i] = exp_r[i];
        end
        #1;
        if (!rst) check({tag, " R2/R3 bus"}, bus_out, bus_e);
        for (int i = 0; i < 4; i++)
            check({tag, " R5 before edge"}, reg_out[i*W +: W], exp_r[i]);
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            exp_r[i] = nxt[i];
            check(tag, reg_out[i*W +: W], exp_r[i]);
        end
    endtask

    task automatic preload(input logic [W-1:0] seed);
        idle();
        par_ld = 4'hF;
        for (int i = 0; i < 4; i++) par_data[i*W +: W] = seed + W'(i * 8'h35) + 8'h11;
        apply("R9 parallel load");
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk_cnt++; fail_cnt++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", chk_cnt - fail_cnt, chk_cnt);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        for (int i = 0; i < 4; i++) exp_r[i] = '0;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 4; i++) check("R1 reset state", reg_out[i*W +: W], '0);

        // R9: distinct direct loads
        preload(8'h40);

        // R2 / R3: every source with bus enabled and disabled
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 2; e++) begin
                idle(); src_sel = s[1:0]; bus_en = e[0];
                apply("R2/R3 source sweep");
            end
        end

        // R4 / R5 / R6: every source-destination pair over the bus
        for (int s = 0; s < 4; s++) begin
            for (int d = 0; d < 4; d++) begin
                preload(W'(s * 16 + d * 3));
                src_sel = s[1:0]; bus_en = 1; ld_en = 4'b1 << d;
                apply("R4/R6 transfer");
            end
        end

        // R3: load with bus disabled writes zero
        preload(8'h09);
        bus_en = 0; src_sel = 2; ld_en = 4'b0010;
        apply("R3 idle bus load");

        // R4: held load repeats; source changes through the parallel path
        preload(8'h21);
        bus_en = 1; src_sel = 0; ld_en = 4'b0010;
        par_ld = 4'b0001; par_data = '0; par_data[W-1:0] = 8'h7E;
        apply("R4 held load edge 1");
        par_ld = 0;
        apply("R4 held load edge 2");
        idle();
        apply("R4 hold when idle");

        // R9 over R4: parallel load wins on the same register
        preload(8'h55);
        bus_en = 1; src_sel = 3; ld_en = 4'b0100; par_ld = 4'b0100;
        par_data[2*W +: W] = 8'hC9;
        apply("R9 priority over bus");

        // R7: every swap pair, including equal indices
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                preload(W'(a * 40 + b * 7));
                xchg_en = 1; xchg_a = a[1:0]; xchg_b = b[1:0];
                apply("R7 swap");
            end
        end

        // R8: swap overrides loads on its pair, others still load
        preload(8'h63);
        xchg_en = 1; xchg_a = 1; xchg_b = 3;
        bus_en = 1; src_sel = 0; ld_en = 4'b1110; par_ld = 4'b1010;
        par_data = {8'hEE, 8'hDD, 8'hCC, 8'hBB};
        apply("R8 swap priority");

        // R1: reset overrides everything
        preload(8'h77);
        rst = 1; xchg_en = 1; xchg_a = 0; xchg_b = 2;
        bus_en = 1; ld_en = 4'hF; par_ld = 4'hF; par_data = '1;
        apply("R1 reset priority");
        idle();
        apply("R1 after reset");

        done = 1;
        $display("%0d/%0d checks passed", chk_cnt - fail_cnt, chk_cnt);
        $finish;
    end
endmodule